// File: doc/BRIEF.md
# B3ZS/HDB3 Line Encoder

This block turns a serial NRZ bit stream into the two logic rails that drive a bipolar (AMI) line transmitter: one rail marks positive pulses, the other negative pulses. Ordinary ones become pulses of alternating polarity. Long runs of zeros are replaced with a substitution pattern that carries a deliberate bipolar violation, so the far-end clock recovery always sees enough pulses. One input selects the three-zero code used at DS3/STS-1 rates (B3ZS) or the four-zero code used at E3 rates (HDB3).

A second mode bypasses the encoder. A framer that already produces encoded rails drives them onto the same two inputs, and they pass to the outputs with the same latency. A polarity input picks which edge of the transmit clock samples the inputs. This lets the block sit behind a framer that launches data on either edge. The encoder holds a four-entry look-ahead window. It detects a zero run before the first zero of that run leaves, so every output lags its input by a fixed four clocks.

Top module: `zsub_line_encoder`

## Requirements
- R1: While `rst_n` is low, both rails are low. For the first four active edges after reset is released, both rails stay low while the look-ahead window fills.
- R2: A bit sampled on active edge e affects the rails right after active edge e+4. The latency is the same in encode and bypass modes.
- R3: In encode mode (`enc_en`=1), ordinary ones give pulses of alternating polarity. The first pulse after reset is positive (`line_pos`).
- R4: With `hdb3_sel`=0, every run of three zeros is replaced. The code is 00V when the count of non-violation pulses since the last violation is odd, and B0V when it is even. The count starts even at reset and clears after each V.
- R5: With `hdb3_sel`=1, every run of four zeros is replaced. The code is 000V when that count is odd, and B00V when it is even.
- R6: A V pulse repeats the polarity of the pulse just before it. A B pulse takes the polarity opposite to the pulse just before it, as an ordinary one does.
- R7: Once the window has filled, the encoded rails never show more than two consecutive zero cycles with B3ZS, or more than three with HDB3.
- R8: In encode mode, data is taken from `tx_pos` only. `tx_neg` has no effect on the rails.
- R9: In bypass mode (`enc_en`=0), a high `tx_pos` alone gives a positive mark and a high `tx_neg` alone gives a negative mark. When both are high, both rails stay low.
- R10: `line_pos` and `line_neg` are never high in the same cycle.
- R11: With `clk_inv`=0, inputs are sampled and outputs updated on the rising edge of `clk`. With `clk_inv`=1, both happen on the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_inv | input | 1 | 1 = use the falling edge of `clk` as the active edge |
| enc_en | input | 1 | 1 = encode NRZ data, 0 = pass encoded rails through |
| hdb3_sel | input | 1 | 0 = B3ZS substitution, 1 = HDB3 substitution |
| tx_pos | input | 1 | NRZ data (encode) or positive rail (bypass) |
| tx_neg | input | 1 | Negative rail in bypass mode; ignored when encoding |
| line_pos | output | 1 | Positive mark indication |
| line_neg | output | 1 | Negative mark indication |

## Verification
Two actions can fall on the same active edge. At the head of the window, a new zero run is detected. At the tail, a pending substitution slot is resolved into a B pulse or a zero. The B-or-zero choice must count the pulse that leaves on that same edge. Long all-zero stretches make substitutions follow each other back to back, and ones placed directly before zero runs of every length provoke this collision. Each rail pattern is judged against an independent whole-sequence encoder model in the bench, and against hand-derived sequences for the short cases.

// File: rtl/zsub_line_encoder.sv
module zsub_line_encoder (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_inv,
  input  logic enc_en,
  input  logic hdb3_sel,
  input  logic tx_pos,
  input  logic tx_neg,
  output logic line_pos,
  output logic line_neg
);
  localparam logic [1:0] K_PLAIN = 2'd0;
  localparam logic [1:0] K_SUB   = 2'd1;
  localparam logic [1:0] K_VIOL  = 2'd2;
  localparam logic [1:0] K_FILL  = 2'd3;

  logic            aclk;
  logic [3:0]      bit_q, bit_d;
  logic [3:0][1:0] kind_q, kind_d;
  logic [3:0][1:0] byp_q;
  logic            par_q, par_d, pol_q, pol_d;
  logic            fire, fire_pol;

  assign aclk = clk ^ clk_inv;

  // window: slot 0 newest, slot 3 leaves next; flagged slots carry bit 1 so they end a run
  always_comb begin
    bit_d  = {bit_q[2:0], tx_pos};
    kind_d = {kind_q[2:0], K_PLAIN};
    if (hdb3_sel && bit_d == 4'b0000) begin
      bit_d     = 4'b1001;
      kind_d[3] = K_SUB;
      kind_d[0] = K_VIOL;
    end else if (!hdb3_sel && bit_d[2:0] == 3'b000) begin
      bit_d[2]  = 1'b1;
      bit_d[0]  = 1'b1;
      kind_d[2] = K_SUB;
      kind_d[0] = K_VIOL;
    end
  end

  // B-or-zero choice is made as the slot leaves, when the parity is final
  always_comb begin
    fire     = 1'b0;
    fire_pol = pol_q;
    case (kind_q[3])
      K_PLAIN: if (bit_q[3]) begin fire = 1'b1; fire_pol = ~pol_q; end
      K_SUB:   if (!par_q)   begin fire = 1'b1; fire_pol = ~pol_q; end
      K_VIOL:  begin fire = 1'b1; fire_pol = pol_q; end
      default: fire = 1'b0;
    endcase
    pol_d = fire ? fire_pol : pol_q;
    par_d = !fire ? par_q : (kind_q[3] == K_VIOL) ? 1'b0 : ~par_q;
  end

  always_ff @(posedge aclk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= '1;
      kind_q   <= {4{K_FILL}};
      byp_q    <= '0;
      par_q    <= 1'b0;
      pol_q    <= 1'b0;
      line_pos <= 1'b0;
      line_neg <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      kind_q <= kind_d;
      byp_q  <= {byp_q[2:0], {tx_pos & ~tx_neg, tx_neg & ~tx_pos}};
      if (enc_en) begin
        par_q    <= par_d;
        pol_q    <= pol_d;
        line_pos <= fire & fire_pol;
        line_neg <= fire & ~fire_pol;
      end else begin
        line_pos <= byp_q[3][1];
        line_neg <= byp_q[3][0];
      end
    end
  end
endmodule

module zsub_line_encoder_chk (
  input logic aclk,
  input logic rst_n,
  input logic enc_en,
  input logic hdb3_sel,
  input logic tx_pos,
  input logic tx_neg,
  input logic line_pos,
  input logic line_neg
);
  logic [2:0] cnt;
  logic [2:0] zrun;

  always_ff @(posedge aclk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt != 3'd7) cnt <= cnt + 3'd1;
  end

  always_ff @(posedge aclk or negedge rst_n) begin
    if (!rst_n) zrun <= '0;
    else if (!enc_en || cnt < 3'd5) zrun <= '0;
    else if (!line_pos && !line_neg) zrun <= (zrun == 3'd7) ? zrun : zrun + 3'd1;
    else zrun <= '0;
  end

  AST_RAILS_EXCLUSIVE: assert property (@(posedge aclk) disable iff (!rst_n)
    !(line_pos && line_neg)); // R10

  AST_FILL_QUIET: assert property (@(posedge aclk) disable iff (!rst_n)
    (cnt < 3'd5) |-> (!line_pos && !line_neg)); // R1

  AST_ZERO_RUN_LIMIT: assert property (@(posedge aclk) disable iff (!rst_n)
    enc_en |-> (zrun <= (hdb3_sel ? 3'd3 : 3'd2))); // R7

  AST_BYPASS_RAILS: assert property (@(posedge aclk) disable iff (!rst_n)
    (cnt == 3'd7 && !enc_en && !$past(enc_en, 5)) |->
      (line_pos == ($past(tx_pos, 5) && !$past(tx_neg, 5)) &&
       line_neg == ($past(tx_neg, 5) && !$past(tx_pos, 5)))); // R9
endmodule

bind zsub_line_encoder zsub_line_encoder_chk u_chk (
  .aclk(aclk), .rst_n(rst_n), .enc_en(enc_en), .hdb3_sel(hdb3_sel),
  .tx_pos(tx_pos), .tx_neg(tx_neg), .line_pos(line_pos), .line_neg(line_neg)
);

// File: tb/tb_zsub_line_encoder.sv
module tb_zsub_line_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_inv = 1'b0, enc_en = 1'b1, hdb3_sel = 1'b0;
  logic tx_pos = 1'b0, tx_neg = 1'b0;
  logic line_pos, line_neg;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  bit act_p[40], act_n[40], exp_p[40], exp_n[40];

  always #5 clk = ~clk;

  zsub_line_encoder dut (.*);

  // {enc_en, hdb3_sel, clk_inv, neg rail, data}
  localparam logic [66:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'hB3A0_1C05},
    {1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0102_4811},
    {1'b1, 1'b1, 1'b0, 32'hA5A5_A5A5, 32'h8001_2344},
    {1'b1, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0003},
    {1'b1, 1'b0, 1'b0, 32'h1234_5678, 32'h0000_0000},
    {1'b1, 1'b1, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF},
    {1'b0, 1'b0, 1'b0, 32'h0F0F_3C3C, 32'h00FF_3366},
    {1'b0, 1'b1, 1'b1, 32'h5555_AAAA, 32'h3333_CCCC}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_active(input bit inv);
    if (inv) @(negedge clk);
    else @(posedge clk);
  endtask

  // independent whole-sequence encoder
  task automatic model(input bit hdb3, input bit [39:0] d);
    int i = 0;
    int n = hdb3 ? 4 : 3;
    bit par = 1'b0, lp = 1'b0;
    for (int k = 0; k < 40; k++) begin exp_p[k] = 1'b0; exp_n[k] = 1'b0; end
    while (i < 40) begin
      bit run = (i + n <= 40);
      for (int j = 0; j < n; j++) if (run && i + j < 40 && d[i+j]) run = 1'b0;
      if (run) begin
        if (!par) begin lp = ~lp; exp_p[i] = lp; exp_n[i] = ~lp; end
        exp_p[i+n-1] = lp; exp_n[i+n-1] = ~lp;
        par = 1'b0;
        i += n;
      end else begin
        if (d[i]) begin lp = ~lp; exp_p[i] = lp; exp_n[i] = ~lp; par = ~par; end
        i++;
      end
    end
  endtask

  task automatic run_vec(input bit en, input bit hdb3, input bit inv,
                         input logic [31:0] negv, input logic [31:0] datav,
                         input bit cmp, input string req);
    bit [39:0] d  = {8'h00, datav};
    bit [39:0] ng = {8'h00, negv};
    int zr = 0;
    rst_n = 1'b0; clk_inv = inv; enc_en = en; hdb3_sel = hdb3;
    tx_pos = 1'b0; tx_neg = 1'b0;
    repeat (3) @(posedge clk);
    for (int s = 0; s < 45; s++) begin
      wait_active(inv);
      #2;
      if (s == 0) rst_n = 1'b1;
      tx_pos = (s < 40) ? d[s] : 1'b0;
      tx_neg = (s < 40) ? ng[s] : 1'b0;
      #4;
      check(!(line_pos && line_neg), "R10", "both rails high", 1, 0);
      if (s < 5) check(!line_pos && !line_neg, "R1", "rails during fill",
                       {line_pos, line_neg}, 0);
      else begin act_p[s-5] = line_pos; act_n[s-5] = line_neg; end
    end
    if (cmp) begin
      if (en) model(hdb3, d);
      else for (int k = 0; k < 40; k++) begin
        exp_p[k] = d[k] & ~ng[k]; exp_n[k] = ng[k] & ~d[k];
      end
      for (int k = 0; k < 36; k++)
        check(act_p[k] == exp_p[k] && act_n[k] == exp_n[k], req, "rail pair",
              {act_p[k], act_n[k]}, {exp_p[k], exp_n[k]});
    end
    if (en) begin
      for (int k = 0; k < 36; k++) begin
        zr = (act_p[k] || act_n[k]) ? 0 : zr + 1;
        check(zr <= (hdb3 ? 3 : 2), "R7", "zero run length", zr, hdb3 ? 3 : 2);
      end
    end
  endtask

  task automatic check_mask(input logic [7:0] pm, input logic [7:0] nm, input string req);
    for (int k = 0; k < 8; k++)
      check(act_p[k] == pm[k] && act_n[k] == nm[k], req, "directed rail pair",
            {act_p[k], act_n[k]}, {pm[k], nm[k]});
  endtask

  initial begin
    #2ms;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // reset state with reset held (R1)
    #23;
    check(!line_pos && !line_neg, "R1", "rails in reset", {line_pos, line_neg}, 0);

    // table: R2 latency, R4/R5 codes, R8 neg ignored (junk on tx_neg), R9 bypass, R11 inverted edge
    for (int v = 0; v < 8; v++)
      run_vec(VEC[v][66], VEC[v][65], VEC[v][64], VEC[v][63:32], VEC[v][31:0], 1'b1,
              VEC[v][66] ? "R2/R4/R5/R8/R11" : "R9/R11");

    // R5 R6: HDB3 all zeros -> B00V +, then B00V -
    run_vec(1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
    check_mask(8'h09, 8'h90, "R5/R6");
    // R4 R6: B3ZS 1,1,0,0,0 -> + - B+ 0 V+ then B- 0 V-
    run_vec(1'b1, 1'b0, 1'b0, 32'h0, 32'h3, 1'b0, "R4");
    check_mask(8'h15, 8'hA2, "R4/R6");
    // R5: HDB3 1,0,0,0,0 -> + 0 0 0 V+ then B- 0 0 V-
    run_vec(1'b1, 1'b1, 1'b0, 32'h0, 32'h1, 1'b0, "R5");
    check_mask(8'h11, 8'h20, "R5");
    // R4: B3ZS 1,0,0,0 -> + 0 0 V+ then B- 0 V- then B+
    run_vec(1'b1, 1'b0, 1'b0, 32'h0, 32'h1, 1'b0, "R4");
    check_mask(8'h89, 8'h50, "R4");
    // R3: alternation of ordinary ones, first positive
    run_vec(1'b1, 1'b0, 1'b0, 32'h0, 32'h5, 1'b0, "R3");
    check_mask(8'h29, 8'h44, "R3");
    // R8: same stream with tx_neg held high gives identical rails
    run_vec(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h5, 1'b0, "R8");
    check_mask(8'h29, 8'h44, "R8");
    // R9 R10: bypass with both rails high gives no mark, single rails pass
    run_vec(1'b0, 1'b0, 1'b0, 32'h5, 32'h3, 1'b0, "R9");
    check_mask(8'h02, 8'h04, "R9/R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule